// File: doc/BRIEF.md
# Byte-Lane Flow-Through Synchronous Static Memory

This block is a single-port synchronous static memory whose word is split into independent byte lanes. Each lane holds eight data bits plus one parity bit. A burst sequencer in front of it supplies the word address and a select on every clock. The block samples them on the rising edge, together with the write controls and the write data. A write lands in the array at that same edge, so no separate write strobe is generated. A full-word write comes from the global write control, and a lane-by-lane write from the write enable qualified by the per-lane byte controls.

Reads are flow-through. The address captured at the edge indexes the array directly, and the word reaches the data outputs in the cycle that follows that edge, with no output register in between. An asynchronous, active-low output enable gates the pads. The block reports the pad state on a drive-enable output, and the data output reads as zero whenever the pads are released. The default size is 1K words of 36 bits. Setting the address width to 15 gives 32K words.

Top module: `sram_ft_bw`

## Requirements
- R1: The word is LANES lanes of LANE_W bits (defaults 4 and 9, giving 36 bits), with 2**ADDR_W words. Lane i occupies bits [i*LANE_W +: LANE_W] of d_in and q_out, and byte control bw_n[i] governs lane i.
- R2: On a selected cycle with gw_n low, every lane at the captured address takes d_in, whatever the levels of we_n and bw_n.
- R3: On a selected cycle with gw_n high and we_n low, only the lanes whose bw_n bit is low are written, and the other lanes keep their contents. With bw_n all high, no lane changes.
- R4: With gw_n high, we_n low and every bw_n bit low, the whole word is written.
- R5: A write takes effect at the edge that captures it. A read of the same address on the next cycle returns the new data.
- R6: A selected cycle with gw_n and we_n both high is a read. With oe_n low, q_out holds the stored word for the address captured at that edge right after the edge, with no extra cycle of latency.
- R7: oe_n acts without the clock. While oe_n is high, q_en is low. During a read cycle, lowering oe_n raises q_en at once.
- R8: After a write cycle or a deselected cycle (sel low), q_en is low whatever the level of oe_n.
- R9: While q_en is low, q_out is all zeros.
- R10: Synchronous active-high reset leaves q_en low. It does not alter the memory contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs except oe_n are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Cycle select from the sequencer, active high |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low; writes all lanes |
| we_n | input | 1 | Write enable, active low; qualified by bw_n |
| bw_n | input | LANES | Per-lane byte write, active low |
| d_in | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q_out | output | LANES*LANE_W | Read data, zero while pads are released |
| q_en | output | 1 | Pad drive enable; low means high impedance |

## Verification
The bench builds the block with ADDR_W set to 6, which gives 64 words. The whole array can then be preloaded with known words in a few dozen cycles, and several hundred random operations hit each address many times. This brings overwrites of single lanes, back-to-back write and read of one word, and reads after partial writes within reach. LANES and LANE_W stay at 4 and 9, so every byte mask of the default lane count is exercised, including the all-high mask that writes nothing.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_LANE_W = 9;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_ft_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES
) (
  input  logic             sel,
  input  logic             gw_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  output cyc_e             cyc,
  output logic [LANES-1:0] lane_we
);
  always_comb begin
    cyc     = CYC_IDLE;
    lane_we = '0;
    if (sel) begin
      if (!gw_n) begin
        cyc     = CYC_WRITE;
        lane_we = '1;
      end else if (!we_n) begin
        cyc     = CYC_WRITE;
        lane_we = ~bw_n;
      end else begin
        cyc = CYC_READ;
      end
    end
  end

  // R2: the global write always reaches every lane
  always_comb begin
    if (sel && !gw_n) a_r2_global_all: assert (&lane_we);
  end

  // R3: without any write control no lane is written
  always_comb begin
    if (gw_n && we_n) a_r3_no_stray_write: assert (lane_we == '0);
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned W      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R5: a lane write is present in the array one edge later
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int unsigned W = 36
) (
  input  logic         rd_valid,
  input  logic         oe_n,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] q_out,
  output logic         q_en
);
  assign q_en  = rd_valid && !oe_n;
  assign q_out = q_en ? rdata : '0;

  // R7: a high output enable releases the pads
  always_comb begin
    if (oe_n) a_r7_oe_release: assert (!q_en);
  end

  // R9: released pads read as zero
  always_comb begin
    if (!q_en) a_r9_zero_when_off: assert (q_out == '0);
  end
endmodule

// File: rtl/sram_ft_bw.sv
module sram_ft_bw
  import sram_ft_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gw_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] q_out,
  output logic                    q_en
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  cyc_e              cyc;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] addr_r;
  logic              rd_r;
  logic [WORD_W-1:0] rword;

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .sel     (sel),
    .gw_n    (gw_n),
    .we_n    (we_n),
    .bw_n    (bw_n),
    .cyc     (cyc),
    .lane_we (lane_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_r <= 1'b0;
    end else begin
      rd_r <= (cyc == CYC_READ);
    end
    if (sel) addr_r <= addr;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .we    (lane_we[i]),
      .waddr (addr),
      .wdata (d_in[i*LANE_W +: LANE_W]),
      .raddr (addr_r),
      .rdata (rword[i*LANE_W +: LANE_W])
    );
  end

  sram_out_stage #(.W(WORD_W)) u_out (
    .rd_valid (rd_r),
    .oe_n     (oe_n),
    .rdata    (rword),
    .q_out    (q_out),
    .q_en     (q_en)
  );

  // R8: write cycles leave the pads released
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel && (!gw_n || !we_n)) |=> !q_en);

  // R8: deselected cycles leave the pads released
  a_r8_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !q_en);

  // R10: the first cycle out of reset does not drive
  a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !q_en);
endmodule

// File: tb/sram_ft_bw_bench.sv
`timescale 1ns/100ps
module sram_ft_bw_bench;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          gw_n = 1'b1;
  logic          we_n = 1'b1;
  logic [NL-1:0] bw_n = '1;
  logic [WW-1:0] d_in = '0;
  logic          oe_n = 1'b1;
  logic [WW-1:0] q_out;
  logic          q_en;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  sram_ft_bw #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_sram_ft_bw (
    .clk(clk), .rst(rst), .sel(sel), .addr(addr), .gw_n(gw_n), .we_n(we_n),
    .bw_n(bw_n), .d_in(d_in), .oe_n(oe_n), .q_out(q_out), .q_en(q_en)
  );

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old,
      input logic [WW-1:0] d, input logic [NL-1:0] mask);
    logic [WW-1:0] r = old;
    for (int i = 0; i < NL; i++) if (mask[i]) r[i*LW +: LW] = d[i*LW +: LW];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
      input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input bit exp_en, input logic [WW-1:0] exp_q, input string req);
    check(q_en == exp_en, req, {35'd0, q_en}, {35'd0, exp_en});
    check(q_out == exp_q, req, q_out, exp_q);
  endtask

  task automatic op(input logic s, input logic g, input logic w, input logic [NL-1:0] b,
      input int a, input logic [WW-1:0] d, input logic oe, input string req);
    bit rd;
    logic [WW-1:0] mask;
    @(negedge clk);
    sel = s; gw_n = g; we_n = w; bw_n = b; addr = AW'(a); d_in = d; oe_n = oe;
    rd = s && g && w;
    if (s && !g) model[a] = merge(model[a], d, '1);
    else if (s && !w) model[a] = merge(model[a], d, ~b);
    mask = model[a];
    @(posedge clk); #1;
    if (rd && !oe) chk_out(1'b1, mask, req);
    else chk_out(1'b0, '0, req);
  endtask

  function automatic logic [WW-1:0] rnd_word();
    return {$urandom, $urandom} & {WW{1'b1}};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] w0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk_out(1'b0, '0, "R10 reset");
    @(negedge clk); rst = 1'b0;

    // R2: fill with gw_n low while we_n/bw_n stay high
    for (int i = 0; i < DEPTH; i++) op(1, 0, 1, 4'hF, i, rnd_word(), 0, "R2 fill");
    for (int i = 0; i < 8; i++) op(1, 1, 1, 4'hF, i * 7, '0, 0, "R2 readback");

    // R2: gw_n overrides a partial byte mask
    op(1, 0, 0, 4'b0111, 5, 36'h1_2345_6789, 0, "R2 override");
    op(1, 1, 1, 4'hF, 5, '0, 0, "R2 override read");

    // R1/R3: lanes 0 and 2 written only
    op(1, 1, 0, 4'b1010, 9, 36'hA_BCDE_F012, 0, "R3 partial");
    op(1, 1, 1, 4'hF, 9, '0, 0, "R1 R3 lane placement");

    // R3: we_n low with no byte selected changes nothing
    w0 = model[11];
    op(1, 1, 0, 4'hF, 11, 36'hF_FFFF_FFFF, 0, "R3 empty mask");
    op(1, 1, 1, 4'hF, 11, '0, 0, "R3 empty mask read");
    check(model[11] == w0, "R3 model", model[11], w0);

    // R4 + R5: full word, read on next cycle
    op(1, 1, 0, 4'h0, 20, 36'h5_A5A5_A5A5, 0, "R4 R5 write");
    op(1, 1, 1, 4'hF, 20, '0, 0, "R4 R5 read next");

    // R6: consecutive reads of different words, no lag
    op(1, 1, 1, 4'hF, 30, '0, 0, "R6 first");
    op(1, 1, 1, 4'hF, 31, '0, 0, "R6 second");

    // R7: async output enable
    op(1, 1, 1, 4'hF, 30, '0, 1, "R7 oe high");
    oe_n = 1'b0; #0.5;
    chk_out(1'b1, model[30], "R7 oe drops");
    oe_n = 1'b1; #0.5;
    chk_out(1'b0, '0, "R7 oe rises");

    // R8: deselect and write with oe_n low
    op(0, 1, 1, 4'hF, 30, '0, 0, "R8 deselect");
    op(1, 0, 1, 4'hF, 40, rnd_word(), 0, "R8 write");

    // R10: reset keeps contents
    @(negedge clk); rst = 1'b1; sel = 1'b0;
    @(posedge clk); #1;
    chk_out(1'b0, '0, "R10 in reset");
    @(negedge clk); rst = 1'b0;
    op(1, 1, 1, 4'hF, 40, '0, 0, "R10 contents kept");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k = $urandom_range(0, 9);
      int a = $urandom_range(0, DEPTH - 1);
      logic o = ($urandom_range(0, 3) == 0);
      if (k < 2) op(1, 0, $urandom_range(0, 1), 4'($urandom), a, rnd_word(), o, "R2 rand");
      else if (k < 5) op(1, 1, 0, 4'($urandom), a, rnd_word(), o, "R3 rand");
      else if (k < 6) op(0, 4'($urandom) > 7, 1, 4'hF, a, rnd_word(), o, "R8 rand");
      else op(1, 1, 1, 4'($urandom), a, rnd_word(), o, "R6 rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule